// File: doc/BRIEF.md
# Ping-pong ECC sector transfer engine

This block moves one page of NAND data, one 1024-byte ECC step at a time, between the flash byte bus and a pair of on-chip step buffers. Software starts each step by writing a control word that names the direction, the target buffer, enable, auto-correct and a start bit. The engine then streams exactly one step of bytes, waits for the external BCH decoder to post its status word for that step, latches it and raises a ready flag.

The two buffers alternate: step k of a page is normally aimed at buffer k mod 2. The second buffer sits 0x400 bytes above the first in the host view. The host may start the next step into one buffer while it copies out the buffer that was just filled. A page-level result is kept across steps. It holds the largest corrected-error count seen so far, or all ones once any step was uncorrectable. Computing ECC itself is outside this block; the decoder is modelled as a status input.

Top module: `spp_engine`

## Requirements
- R1: Control word fields: bit 0 reset, bit 1 direction (0 = flash to buffer, 1 = buffer to flash), bit 2 start, bit 3 enable, bit 4 buffer select, bit 5 count, bit 10 auto-correct. Reading it back returns the last written word with bit 0 as 0 and bit 20 replaced by the ready flag.
- R2: A step begins only on a control write with start=1, enable=1 and reset=0, while the engine is idle and the previously written word had start=0. Writing start=1 again without clearing it first starts nothing.
- R3: A start written while a step runs is ignored. The running step finishes after its full byte count, with the buffer and direction it was started with.
- R4: In flash-to-buffer direction, each `nand_in_valid` cycle stores `nand_in_data` at the next offset (from 0 upward) of the selected buffer. A step ends after STEP_BYTES bytes. The host address is {buffer, offset}: bit 10 selects the buffer at the default size. `host_rd_data` shows the addressed byte one cycle after the address.
- R5: Filling one buffer leaves every byte of the other buffer unchanged.
- R6: In buffer-to-flash direction, the engine drives the selected buffer's bytes in offset order on `nand_out_data` with `nand_out_valid` high, advancing on each cycle that `nand_out_ready` is high. `nand_out_valid` is low once the last byte is taken.
- R7: After the last byte the engine waits for `ecc_valid`. On that cycle it captures `ecc_status`, and `ready` is high from the next cycle. `ready` is low from the cycle after an accepted start and stays low while a step runs.
- R8: `step_uncorr` is bit 2 of the captured status. `step_err_cnt` is {status bit 27, status bits 7:3}.
- R9: `page_result` is the highest `step_err_cnt` since the last clear, or 0xFF (sticky) once any step was uncorrectable. A control write with bit 0 set clears it to 0, aborts any step and clears `ready`.
- R10: On each accepted start, the ECC control register's region field (bits 7:5) reads 0 from the next cycle; its other bits keep their written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback with ready at bit 20 |
| eccctl_we | input | 1 | ECC control register write strobe |
| eccctl_wdata | input | 32 | ECC control register write data |
| eccctl_rdata | output | 32 | ECC control register readback |
| nand_in_valid | input | 1 | Flash byte available (flash-to-buffer) |
| nand_in_data | input | 8 | Flash byte |
| nand_out_valid | output | 1 | Buffer byte offered to flash |
| nand_out_data | output | 8 | Buffer byte to flash |
| nand_out_ready | input | 1 | Flash side takes the offered byte |
| ecc_valid | input | 1 | Decoder status for the step is valid |
| ecc_status | input | 32 | Decoder status word |
| host_we | input | 1 | Host buffer write strobe |
| host_addr | input | ADDR_W | Host buffer address {buffer, offset} |
| host_wdata | input | 8 | Host buffer write byte |
| host_rd_data | output | 8 | Host buffer read byte, one cycle after address |
| step_status | output | 32 | Last captured status word |
| step_err_cnt | output | 6 | Error count of the last step |
| step_uncorr | output | 1 | Last step was uncorrectable |
| page_result | output | 8 | Page-wide maximum count or 0xFF |
| ready | output | 1 | Step finished and status posted |

## Verification
An accepted start shows its effects one clock later: `ready` falls and the region field reads zero. A buffer read returns data one clock after its address. `ready`, the step status and the page result change one clock after the `ecc_valid` cycle. The bench drives every input on the falling edge and reads outputs on the following falling edge, so each result is compared in the first cycle it is due. Bytes sent toward flash are compared by a monitor half a cycle before the edge that consumes them, against a queue filled when the buffer was written.

// File: rtl/spp_pkg.sv
package spp_pkg;

    // control word bit positions
    localparam int CB_RST  = 0;
    localparam int CB_DIR  = 1;
    localparam int CB_GO   = 2;
    localparam int CB_EN   = 3;
    localparam int CB_BUF  = 4;
    localparam int CB_CNT  = 5;
    localparam int CB_ACOR = 10;
    localparam int CB_RDY  = 20;

    // ECC control region field
    localparam int REGION_LSB = 5;
    localparam int REGION_W   = 3;

    // decoder status word
    localparam int ST_UNCORR = 2;
    localparam int ST_HI     = 27;

    localparam logic [7:0] PAGE_BAD = 8'hFF;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MOVE = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    // six-bit error count: low five bits at 7:3, top bit far away at 27
    function automatic logic [5:0] err_count(input logic [31:0] s);
        return {s[ST_HI], s[7:3]};
    endfunction

endpackage

// File: rtl/spp_buf.sv
module spp_buf #(
    parameter int STEP_BYTES = 1024,
    localparam int ADDR_W = $clog2(STEP_BYTES) + 1
) (
    input  logic              clk,
    input  logic              eng_we,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [7:0]        eng_wdata,
    output logic [7:0]        eng_rdata,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata
);
    localparam int DEPTH = 2 * STEP_BYTES;

    logic [7:0] mem [DEPTH];

    // engine writes win over host writes
    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem[eng_addr] <= eng_wdata;
        end else if (host_we) begin
            mem[host_addr] <= host_wdata;
        end
        host_rdata <= mem[host_addr];
    end

    assign eng_rdata = mem[eng_addr];

endmodule

// File: rtl/spp_fold.sv
module spp_fold
    import spp_pkg::*;
(
    input  logic [31:0] status,
    input  logic [7:0]  page_in,
    output logic [7:0]  page_out
);
    logic [5:0] cnt;
    logic       unc;

    always_comb begin
        cnt = err_count(status);
        unc = status[ST_UNCORR];
        if (unc || page_in == PAGE_BAD) begin
            page_out = PAGE_BAD;
        end else if ({2'b00, cnt} > page_in) begin
            page_out = {2'b00, cnt};
        end else begin
            page_out = page_in;
        end
    end

endmodule

// File: rtl/spp_engine.sv
module spp_engine
    import spp_pkg::*;
#(
    parameter int STEP_BYTES = 1024,
    localparam int ADDR_W = $clog2(STEP_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [31:0]       ctl_wdata,
    output logic [31:0]       ctl_rdata,
    input  logic              eccctl_we,
    input  logic [31:0]       eccctl_wdata,
    output logic [31:0]       eccctl_rdata,
    input  logic              nand_in_valid,
    input  logic [7:0]        nand_in_data,
    output logic              nand_out_valid,
    output logic [7:0]        nand_out_data,
    input  logic              nand_out_ready,
    input  logic              ecc_valid,
    input  logic [31:0]       ecc_status,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rd_data,
    output logic [31:0]       step_status,
    output logic [5:0]        step_err_cnt,
    output logic              step_uncorr,
    output logic [7:0]        page_result,
    output logic              ready
);
    localparam int CNT_W = ADDR_W - 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_BYTES - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             buf_sel;
        logic             dir;
        logic             rdy;
        logic [31:0]      ctl;
        logic [31:0]      eccctl;
        logic [31:0]      stat;
        logic [7:0]       page;
    } regs_t;

    regs_t q, d;

    logic       go_edge, start_acc, clr_req;
    logic       in_fire, out_fire, byte_fire;
    logic       busy_w, wait_w;
    logic [7:0] page_next;
    logic [7:0] eng_rdata;

    spp_fold u_fold (
        .status   (ecc_status),
        .page_in  (q.page),
        .page_out (page_next)
    );

    spp_buf #(.STEP_BYTES(STEP_BYTES)) u_buf (
        .clk        (clk),
        .eng_we     (in_fire),
        .eng_addr   ({q.buf_sel, q.cnt}),
        .eng_wdata  (nand_in_data),
        .eng_rdata  (eng_rdata),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rd_data)
    );

    always_comb begin
        busy_w    = (q.ph != PH_IDLE);
        wait_w    = (q.ph == PH_WAIT);
        clr_req   = ctl_we && ctl_wdata[CB_RST];
        // start counts only as a 0 -> 1 change of the written start bit
        go_edge   = ctl_we && ctl_wdata[CB_GO] && !q.ctl[CB_GO];
        start_acc = go_edge && ctl_wdata[CB_EN] && !clr_req && !busy_w;
        in_fire   = (q.ph == PH_MOVE) && !q.dir && nand_in_valid;
        out_fire  = (q.ph == PH_MOVE) && q.dir && nand_out_ready;
        byte_fire = in_fire || out_fire;

        d = q;
        if (ctl_we) begin
            d.ctl         = ctl_wdata;
            d.ctl[CB_RST] = 1'b0;
            d.ctl[CB_RDY] = 1'b0;
        end
        if (eccctl_we) begin
            d.eccctl = eccctl_wdata;
        end

        case (q.ph)
            PH_MOVE: begin
                if (byte_fire) begin
                    d.cnt = q.cnt + CNT_W'(1);
                    if (q.cnt == LAST) begin
                        d.ph = PH_WAIT;
                    end
                end
            end
            PH_WAIT: begin
                if (ecc_valid) begin
                    d.stat = ecc_status;
                    d.page = page_next;
                    d.rdy  = 1'b1;
                    d.ph   = PH_IDLE;
                end
            end
            default: ;
        endcase

        if (start_acc) begin
            d.ph      = PH_MOVE;
            d.cnt     = '0;
            d.buf_sel = ctl_wdata[CB_BUF];
            d.dir     = ctl_wdata[CB_DIR];
            d.rdy     = 1'b0;
            d.eccctl[REGION_LSB +: REGION_W] = '0;
        end

        if (clr_req) begin
            d.ph   = PH_IDLE;
            d.cnt  = '0;
            d.rdy  = 1'b0;
            d.page = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ctl_rdata         = q.ctl;
        ctl_rdata[CB_RDY] = q.rdy;
        eccctl_rdata      = q.eccctl;
        nand_out_valid    = (q.ph == PH_MOVE) && q.dir;
        nand_out_data     = eng_rdata;
        step_status       = q.stat;
        step_err_cnt      = err_count(q.stat);
        step_uncorr       = q.stat[ST_UNCORR];
        page_result       = q.page;
        ready             = q.rdy;
    end

endmodule

// File: rtl/spp_chk.sv
module spp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       waiting,
    input logic       start_acc,
    input logic       clr,
    input logic       ready,
    input logic       ecc_valid,
    input logic [5:0] ecc_cnt,
    input logic       ecc_unc,
    input logic [5:0] step_err_cnt,
    input logic       step_uncorr,
    input logic [7:0] page_result,
    input logic [2:0] region,
    input logic       nand_out_valid
);
    // R2
    start_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> busy);

    // R7
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready);

    // R7
    status_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && ecc_valid && !clr) |=> ready);

    // R8
    status_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && ecc_valid && !clr) |=>
            (step_err_cnt == $past(ecc_cnt) && step_uncorr == $past(ecc_unc)));

    // R9
    page_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_result == 8'hFF && !clr) |=> page_result == 8'hFF);

    // R9
    page_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> page_result >= $past(page_result));

    // R9
    clear_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (page_result == 8'h00 && !ready && !busy));

    // R10
    region_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> region == 3'b000);

    // R6
    out_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_out_valid |-> (busy && !waiting));

endmodule

bind spp_engine spp_chk u_spp_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy_w),
    .waiting        (wait_w),
    .start_acc      (start_acc),
    .clr            (clr_req),
    .ready          (ready),
    .ecc_valid      (ecc_valid),
    .ecc_cnt        ({ecc_status[27], ecc_status[7:3]}),
    .ecc_unc        (ecc_status[2]),
    .step_err_cnt   (step_err_cnt),
    .step_uncorr    (step_uncorr),
    .page_result    (page_result),
    .region         (eccctl_rdata[7:5]),
    .nand_out_valid (nand_out_valid)
);

// File: tb/test_spp_engine.sv
`timescale 1ns/100ps
module test_spp_engine;
    localparam int SB = 1024;
    localparam int AW = $clog2(SB) + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        eccctl_we = 1'b0;
    logic [31:0] eccctl_wdata = '0;
    logic [31:0] eccctl_rdata;
    logic        nand_in_valid = 1'b0;
    logic [7:0]  nand_in_data = '0;
    logic        nand_out_valid;
    logic [7:0]  nand_out_data;
    logic        nand_out_ready = 1'b0;
    logic        ecc_valid = 1'b0;
    logic [31:0] ecc_status = '0;
    logic        host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rd_data;
    logic [31:0] step_status;
    logic [5:0]  step_err_cnt;
    logic        step_uncorr;
    logic [7:0]  page_result;
    logic        ready;

    int n_cmp = 0;
    int n_bad = 0;
    int n_pop = 0;
    logic [7:0] exp_q [$];

    always #2.5 clk = ~clk;

    spp_engine #(.STEP_BYTES(SB)) i_spp_engine (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .eccctl_we(eccctl_we), .eccctl_wdata(eccctl_wdata), .eccctl_rdata(eccctl_rdata),
        .nand_in_valid(nand_in_valid), .nand_in_data(nand_in_data),
        .nand_out_valid(nand_out_valid), .nand_out_data(nand_out_data),
        .nand_out_ready(nand_out_ready),
        .ecc_valid(ecc_valid), .ecc_status(ecc_status),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd_data(host_rd_data),
        .step_status(step_status), .step_err_cnt(step_err_cnt),
        .step_uncorr(step_uncorr), .page_result(page_result), .ready(ready)
    );

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'((i * 7 + s * 29 + 3) & 255);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compare bytes offered to flash on handshake cycles
    always @(negedge clk) begin
        #1;
        if (rst_n && nand_out_valid && nand_out_ready) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected byte", {24'h0, nand_out_data}, 32'hDEAD);
            end else begin
                chk("R6 out byte", {24'h0, nand_out_data}, {24'h0, exp_q.pop_front()});
                n_pop++;
            end
        end
    end

    task automatic ctl_wr(input logic [31:0] w);
        ctl_we = 1'b1;
        ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic run_start(input logic [31:0] w);
        ctl_wr(w & ~32'h4);
        ctl_wr(w | 32'h4);
    endtask

    task automatic feed(input int s, input bit inject);
        for (int i = 0; i < SB; i++) begin
            nand_in_valid = 1'b1;
            nand_in_data = pat(s, i);
            if (inject && i == 300) begin ctl_we = 1'b1; ctl_wdata = 32'h438; end
            if (inject && i == 301) begin ctl_wdata = 32'h43C; end
            if (inject && i == 302) begin ctl_we = 1'b0; end
            @(negedge clk);
        end
        nand_in_valid = 1'b0;
    endtask

    task automatic post_ecc(input logic [31:0] st);
        ecc_valid = 1'b1;
        ecc_status = st;
        @(negedge clk);
        ecc_valid = 1'b0;
    endtask

    task automatic hread(input logic [AW-1:0] a, output logic [7:0] v);
        host_addr = a;
        @(negedge clk);
        v = host_rd_data;
    endtask

    task automatic read_step(input int s, input logic [31:0] cw, input logic [31:0] st);
        run_start(cw);
        chk("R7 ready low after start", {31'h0, ready}, 32'h0);
        feed(s, 1'b0);
        post_ecc(st);
        chk("R7 ready after status", {31'h0, ready}, 32'h1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset ready", {31'h0, ready}, 32'h0);
        chk("R9 reset page", {24'h0, page_result}, 32'h0);
        chk("R1 reset ctl", ctl_rdata, 32'h0);
        chk("R6 reset out valid", {31'h0, nand_out_valid}, 32'h0);

        eccctl_we = 1'b1; eccctl_wdata = 32'h0000_00FF;
        @(negedge clk);
        eccctl_we = 1'b0;
        ctl_wr(32'h428);
        chk("R1 ctl readback", ctl_rdata, 32'h428);

        // step 0 into buffer 0, with a restart attempt mid-step (R3)
        ctl_wr(32'h42C);
        chk("R10 region cleared", eccctl_rdata, 32'h1F);
        chk("R7 ready low", {31'h0, ready}, 32'h0);
        feed(0, 1'b1);
        chk("R7 waits for status", {31'h0, ready}, 32'h0);
        post_ecc(32'h18);
        chk("R3 step ended at full count", {31'h0, ready}, 32'h1);
        chk("R1 ready at bit 20", ctl_rdata, 32'h0010_043C);
        chk("R8 count step0", {26'h0, step_err_cnt}, 32'd3);
        chk("R9 page after step0", {24'h0, page_result}, 32'd3);
        hread(11'h3FF, v);
        chk("R3 original buffer kept", {24'h0, v}, {24'h0, pat(0, 1023)});

        // start bit already set: no new step (R2)
        ctl_wr(32'h43C);
        @(negedge clk);
        chk("R2 repeated start ignored", {31'h0, ready}, 32'h1);

        // step 1 into buffer 1, count with high bit far away
        read_step(1, 32'h43C, 32'h0800_00A8);
        chk("R8 count with bit 27", {26'h0, step_err_cnt}, 32'd53);
        chk("R8 correctable", {31'h0, step_uncorr}, 32'h0);
        chk("R9 page max", {24'h0, page_result}, 32'd53);
        hread(11'h000, v); chk("R5 buf0 off0", {24'h0, v}, {24'h0, pat(0, 0)});
        hread(11'h1FF, v); chk("R5 buf0 off511", {24'h0, v}, {24'h0, pat(0, 511)});
        hread(11'h400, v); chk("R4 buf1 off0", {24'h0, v}, {24'h0, pat(1, 0)});
        hread(11'h7FF, v); chk("R4 buf1 off1023", {24'h0, v}, {24'h0, pat(1, 1023)});

        read_step(2, 32'h42C, 32'h50);
        chk("R9 lower count keeps max", {24'h0, page_result}, 32'd53);
        hread(11'h401, v); chk("R5 buf1 untouched", {24'h0, v}, {24'h0, pat(1, 1)});

        read_step(3, 32'h43C, 32'h0C);
        chk("R8 uncorrectable", {31'h0, step_uncorr}, 32'h1);
        chk("R9 page all ones", {24'h0, page_result}, 32'hFF);

        read_step(4, 32'h42C, 32'h10);
        chk("R8 count step4", {26'h0, step_err_cnt}, 32'd2);
        chk("R9 sticky all ones", {24'h0, page_result}, 32'hFF);

        // buffer-to-flash from buffer 1 (R6)
        for (int i = 0; i < SB; i++) begin
            host_we = 1'b1;
            host_addr = AW'(SB + i);
            host_wdata = pat(7, i);
            exp_q.push_back(pat(7, i));
            @(negedge clk);
        end
        host_we = 1'b0;
        run_start(32'h43E);
        for (int k = 0; k < 5000 && exp_q.size() > 0; k++) begin
            nand_out_ready = (k % 3) != 2;
            @(negedge clk);
        end
        nand_out_ready = 1'b0;
        chk("R6 bytes sent", n_pop, SB);
        chk("R6 valid low after last", {31'h0, nand_out_valid}, 32'h0);
        post_ecc(32'h0);
        chk("R7 ready after send", {31'h0, ready}, 32'h1);

        // clear via bit 0 (R9)
        ctl_wr(32'h1);
        chk("R9 clear page", {24'h0, page_result}, 32'h0);
        chk("R9 clear ready", {31'h0, ready}, 32'h0);
        chk("R1 bit0 reads zero", ctl_rdata, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule